// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 32 level-sensitive interrupt request lines and raises one IRQ toward a processor. Sixteen programmable vector slots each name a source and a handler address. When the processor reads the vector register, the block returns the handler address of the most urgent pending slot. It then holds that priority level in service until software writes the same register. That write marks the end of the handler.

A source that no enabled slot claims is a non-vectored source. It ranks below every slot and is served through a programmable default address. The nesting stack records every level taken into service. While a level is in service, only requests of strictly higher priority can drive the IRQ line. Handlers may therefore nest up to the full number of levels.

A two-state bus machine handles register access. In BUS_IDLE, a request is accepted and the state moves to BUS_ACK. BUS_ACK always returns to BUS_IDLE after one cycle, and requests are ignored while it lasts. Read data and the acknowledge appear together in BUS_ACK.

Top module: `vector_irq_ctrl`

## Requirements
- R1: Slot y (0..15) has a 32-bit handler-address register at byte offset 0x100 + 4*y that reads back what was written.
- R2: Slot y has a control register at byte offset 0x200 + 4*y. Bits [4:0] select the source line and bit 5 enables the slot. A read returns these six bits with the upper bits zero.
- R3: A read of offset 0x030 returns the handler address of the lowest-numbered enabled slot whose source is active and not masked. Slot 0 is the most urgent.
- R4: A slot whose enable bit is clear claims nothing. Its source counts as non-vectored. A read of 0x030 won by a non-vectored source returns the default address.
- R5: The default address register at offset 0x034 reads back what was written. A read of 0x030 with no unmasked request returns it and leaves the nesting stack unchanged.
- R6: A read of 0x030 that finds an unmasked request pushes the winner's level onto the stack. The stack holds 17 levels: slots 0..15 and level 16 for non-vectored sources. While a level is in service, only strictly more urgent requests are unmasked.
- R7: Any write to 0x030 pops the stack. On an empty stack the write has no effect.
- R8: irq_out is high exactly when at least one unmasked request is active.
- R9: Reset clears all registers and the stack, and irq_out and bus_ack are low.
- R10: An accepted request (bus_req in BUS_IDLE) gives bus_ack high for exactly the next cycle. For reads, bus_rdata is valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access complete |
| irq_lines | input | 32 | Level-sensitive interrupt requests |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
irq_out is combinational from irq_lines and the stack top. The bench checks it one time step after changing the lines on a falling edge. Read data and the stack push or pop take effect on the rising edge that accepts the request. The bench samples bus_rdata and the new irq_out on the following falling edge, while bus_ack is high. Nesting is checked by observing irq_out after each push and pop. That includes pops on an empty stack and reads that should not push.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
package vic_pkg;
    localparam logic [11:0] OFF_VECTOR  = 12'h030;
    localparam logic [11:0] OFF_DEFAULT = 12'h034;
    localparam logic [3:0]  PAGE_HADDR  = 4'h1;
    localparam logic [3:0]  PAGE_CTRL   = 4'h2;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_ACK  = 1'b1
    } bus_state_e;
endpackage

// File: rtl/vic_slot_bank.sv
`timescale 1ns/1ps
module vic_slot_bank #(
    parameter int NUM_SLOTS = 16,
    parameter int NUM_SRC   = 32,
    parameter int DW        = 32,
    localparam int SRC_W    = $clog2(NUM_SRC),
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_haddr,
    input  logic                           wr_ctrl,
    input  logic [IDX_W-1:0]               idx,
    input  logic [DW-1:0]                  wdata,
    input  logic [NUM_SRC-1:0]             irq_lines,
    output logic [NUM_SLOTS-1:0][DW-1:0]   haddr,
    output logic [NUM_SLOTS-1:0][SRC_W:0]  ctrl,
    output logic [NUM_SLOTS-1:0]           slot_active,
    output logic [NUM_SRC-1:0]             claimed
);
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic [SRC_W-1:0] src_q;
        logic             en_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                haddr[g] <= '0;
                src_q    <= '0;
                en_q     <= 1'b0;
            end else begin
                if (wr_haddr && idx == IDX_W'(g))
                    haddr[g] <= wdata;
                if (wr_ctrl && idx == IDX_W'(g)) begin
                    src_q <= wdata[SRC_W-1:0];
                    en_q  <= wdata[SRC_W];
                end
            end
        end
        assign ctrl[g]        = {en_q, src_q};
        assign slot_active[g] = en_q & irq_lines[src_q];
    end

    always_comb begin
        claimed = '0;
        for (int s = 0; s < NUM_SLOTS; s++)
            if (ctrl[s][SRC_W])
                claimed[ctrl[s][SRC_W-1:0]] = 1'b1;
    end
endmodule

// File: rtl/vic_prio.sv
`timescale 1ns/1ps
module vic_prio #(
    parameter int NUM_SLOTS = 16,
    localparam int LVL_W    = $clog2(NUM_SLOTS + 2)
) (
    input  logic [NUM_SLOTS-1:0] slot_active,
    input  logic                 nv_active,
    input  logic [LVL_W-1:0]     cur_level,
    output logic                 win_valid,
    output logic [LVL_W-1:0]     win_level
);
    localparam logic [LVL_W-1:0] NV_LEVEL = LVL_W'(NUM_SLOTS);

    always_comb begin
        win_valid = 1'b0;
        win_level = NV_LEVEL;
        if (nv_active && NV_LEVEL < cur_level)
            win_valid = 1'b1;
        for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if (slot_active[s] && LVL_W'(s) < cur_level) begin
                win_valid = 1'b1;
                win_level = LVL_W'(s);
            end
        end
    end
endmodule

// File: rtl/vic_nest_stack.sv
`timescale 1ns/1ps
module vic_nest_stack #(
    parameter int DEPTH  = 17,
    parameter int LVL_W  = 5,
    localparam int DEP_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [LVL_W-1:0] push_level,
    output logic [LVL_W-1:0] top_level,
    output logic [DEP_W-1:0] depth
);
    localparam logic [LVL_W-1:0] IDLE_LEVEL = LVL_W'(DEPTH);

    logic [LVL_W-1:0] mem [DEPTH];
    logic [DEP_W-1:0] top_idx;

    assign top_idx   = depth - 1'b1;
    assign top_level = (depth == '0) ? IDLE_LEVEL : mem[top_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push && depth < DEP_W'(DEPTH)) begin
            mem[depth] <= push_level;
            depth      <= depth + 1'b1;
        end else if (pop && depth != '0) begin
            depth <= depth - 1'b1;
        end
    end
endmodule

// File: rtl/vector_irq_ctrl.sv
`timescale 1ns/1ps
module vector_irq_ctrl #(
    parameter int NUM_SLOTS = 16,
    parameter int NUM_SRC   = 32,
    parameter int DW        = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [11:0]        bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    output logic               bus_ack,
    input  logic [NUM_SRC-1:0] irq_lines,
    output logic               irq_out
);
    import vic_pkg::*;

    localparam int SRC_W = $clog2(NUM_SRC);
    localparam int IDX_W = $clog2(NUM_SLOTS);
    localparam int LVL_W = $clog2(NUM_SLOTS + 2);
    localparam int DEPTH = NUM_SLOTS + 1;
    localparam int DEP_W = $clog2(DEPTH + 1);

    bus_state_e state_q, state_d;
    logic       accept;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (bus_req) state_d = BUS_ACK;
            BUS_ACK:  state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        bus_ack = (state_q == BUS_ACK);
        accept  = (state_q == BUS_IDLE) && bus_req;
    end

    logic hit_vec, hit_def, hit_haddr, hit_ctrl, slot_ok;
    logic [IDX_W-1:0] idx;
    assign idx       = bus_addr[2 +: IDX_W];
    assign slot_ok   = (bus_addr[7:2] < 6'(NUM_SLOTS)) && (bus_addr[1:0] == 2'b00);
    assign hit_vec   = bus_addr == OFF_VECTOR;
    assign hit_def   = bus_addr == OFF_DEFAULT;
    assign hit_haddr = bus_addr[11:8] == PAGE_HADDR && slot_ok;
    assign hit_ctrl  = bus_addr[11:8] == PAGE_CTRL && slot_ok;

    logic [NUM_SLOTS-1:0][DW-1:0]  haddr;
    logic [NUM_SLOTS-1:0][SRC_W:0] ctrl;
    logic [NUM_SLOTS-1:0]          slot_active;
    logic [NUM_SRC-1:0]            claimed;

    vic_slot_bank #(.NUM_SLOTS(NUM_SLOTS), .NUM_SRC(NUM_SRC), .DW(DW)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_haddr   (accept && bus_we && hit_haddr),
        .wr_ctrl    (accept && bus_we && hit_ctrl),
        .idx        (idx),
        .wdata      (bus_wdata),
        .irq_lines  (irq_lines),
        .haddr      (haddr),
        .ctrl       (ctrl),
        .slot_active(slot_active),
        .claimed    (claimed)
    );

    logic             nv_active, win_valid;
    logic [LVL_W-1:0] win_level, cur_level;
    logic [DEP_W-1:0] nest_depth;

    assign nv_active = |(irq_lines & ~claimed);

    vic_prio #(.NUM_SLOTS(NUM_SLOTS)) u_prio (
        .slot_active(slot_active),
        .nv_active  (nv_active),
        .cur_level  (cur_level),
        .win_valid  (win_valid),
        .win_level  (win_level)
    );

    vic_nest_stack #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept && !bus_we && hit_vec && win_valid),
        .pop       (accept && bus_we && hit_vec),
        .push_level(win_level),
        .top_level (cur_level),
        .depth     (nest_depth)
    );

    assign irq_out = win_valid;

    logic [DW-1:0] def_q, rd_mux;

    always_ff @(posedge clk) begin
        if (!rst_n)                           def_q <= '0;
        else if (accept && bus_we && hit_def) def_q <= bus_wdata;
    end

    always_comb begin
        rd_mux = '0;
        if (hit_vec)
            rd_mux = (win_valid && win_level < LVL_W'(NUM_SLOTS))
                     ? haddr[win_level[IDX_W-1:0]] : def_q;
        else if (hit_def)
            rd_mux = def_q;
        else if (hit_haddr)
            rd_mux = haddr[idx];
        else if (hit_ctrl)
            rd_mux = DW'(ctrl[idx]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                  bus_rdata <= '0;
        else if (accept && !bus_we)  bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/vic_checker.sv
`timescale 1ns/1ps
module vic_checker #(
    parameter int NUM_SLOTS = 16,
    parameter int NUM_SRC   = 32,
    localparam int DEP_W    = $clog2(NUM_SLOTS + 2)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_req,
    input logic               bus_we,
    input logic [11:0]        bus_addr,
    input logic               bus_ack,
    input logic [NUM_SRC-1:0] irq_lines,
    input logic               irq_out,
    input logic [DEP_W-1:0]   depth
);
    logic vec_rd, vec_wr;
    assign vec_rd = bus_req && !bus_ack && !bus_we && bus_addr == 12'h030;
    assign vec_wr = bus_req && !bus_ack && bus_we && bus_addr == 12'h030;

    assert_ack_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_ack);
    assert_ack_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);
    assert_quiet_lines_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lines == '0 |-> !irq_out);
    assert_no_push_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_rd && !irq_out |=> $stable(depth));
    assert_push_on_claim_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_rd && irq_out |=> depth == $past(depth) + 1'b1);
    assert_depth_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= DEP_W'(NUM_SLOTS + 1));
    assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_wr && depth == '0 |=> depth == '0);
endmodule

bind vector_irq_ctrl vic_checker #(.NUM_SLOTS(NUM_SLOTS), .NUM_SRC(NUM_SRC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_ack  (bus_ack),
    .irq_lines(irq_lines),
    .irq_out  (irq_out),
    .depth    (nest_depth)
);

// File: tb/vector_irq_ctrl_test.sv
`timescale 1ns/1ps
module vector_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        bus_ack, irq_out;
    logic [31:0] irq_lines = '0;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    vector_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .irq_lines(irq_lines), .irq_out(irq_out)
    );

    localparam logic [31:0] DEF = 32'hDEF0_0000;

    // {lines, expected vector, expected irq}
    localparam logic [64:0] VEC_TABLE [7] = '{
        {32'h0000_0000, DEF,          1'b0},
        {32'h0000_0004, 32'h0000_1030, 1'b1},
        {32'h0000_0084, 32'h0000_1000, 1'b1},
        {32'h0010_0000, 32'h0000_10F0, 1'b1},
        {32'h0000_0200, DEF,          1'b1},
        {32'h0010_0004, 32'h0000_1030, 1'b1},
        {32'h8000_0000, DEF,          1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic we, input logic [11:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic ack);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0;
        rd = bus_rdata;
        ack = bus_ack;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] rd; logic ack;
        xfer(1'b1, a, d, rd, ack);
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] rd; logic ack;
        xfer(1'b0, a, 32'h0, rd, ack);
        check(req, {31'b0, ack}, 32'd1);
        check(req, rd, exp);
    endtask

    task automatic set_lines(input logic [31:0] v);
        @(negedge clk);
        irq_lines = v;
        #1;
    endtask

    initial begin
        #(4 * 20000);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 irq", {31'b0, irq_out}, 32'd0);
        check("R9 ack", {31'b0, bus_ack}, 32'd0);
        rst_n = 1'b1;
        rd_chk("R9 default cleared", 12'h034, 32'h0);
        rd_chk("R9 ctrl cleared", 12'h20C, 32'h0);

        // configure: slot y handler 0x1000+0x10*y
        for (int y = 0; y < 16; y++) wr(12'h100 + 12'(4 * y), 32'h1000 + 32'(16 * y));
        wr(12'h034, DEF);
        wr(12'h200, 32'h27);          // slot0 src7 enabled
        wr(12'h20C, 32'h22);          // slot3 src2 enabled
        wr(12'h214, 32'h09);          // slot5 src9 disabled
        wr(12'h23C, 32'h34);          // slot15 src20 enabled
        rd_chk("R1 slot3 handler", 12'h10C, 32'h1030);
        rd_chk("R1 slot15 handler", 12'h13C, 32'h10F0);
        rd_chk("R2 slot3 ctrl", 12'h20C, 32'h22);
        rd_chk("R2 slot5 ctrl", 12'h214, 32'h09);
        rd_chk("R5 default", 12'h034, DEF);

        // table walk: R3 R4 R5 R8
        for (int i = 0; i < 7; i++) begin
            set_lines(VEC_TABLE[i][64:33]);
            check("R8 table irq", {31'b0, irq_out}, {31'b0, VEC_TABLE[i][0]});
            rd_chk("R3 R4 table vector", 12'h030, VEC_TABLE[i][32:1]);
            wr(12'h030, 32'h0);       // R7 pop (empty pop when nothing pushed)
        end

        // R6 nesting
        set_lines(32'h0010_0000);
        rd_chk("R6 low slot", 12'h030, 32'h10F0);
        check("R6 same level masked", {31'b0, irq_out}, 32'd0);
        set_lines(32'h0010_0004);
        check("R6 higher unmasked", {31'b0, irq_out}, 32'd1);
        rd_chk("R6 nested vector", 12'h030, 32'h1030);
        check("R6 after nest", {31'b0, irq_out}, 32'd0);
        set_lines(32'h8010_0004);
        check("R6 nonvectored masked", {31'b0, irq_out}, 32'd0);
        set_lines(32'h8010_0084);
        check("R6 slot0 unmasked", {31'b0, irq_out}, 32'd1);
        rd_chk("R6 third level", 12'h030, 32'h1000);
        check("R6 top level", {31'b0, irq_out}, 32'd0);
        wr(12'h030, 32'h0);
        check("R7 pop to slot3", {31'b0, irq_out}, 32'd1);
        set_lines(32'h8010_0004);
        check("R7 slot3 in service", {31'b0, irq_out}, 32'd0);
        wr(12'h030, 32'h0);
        check("R7 pop to slot15", {31'b0, irq_out}, 32'd1);
        wr(12'h030, 32'h0);
        wr(12'h030, 32'h0);           // R7 extra pop on empty
        set_lines(32'h0);
        check("R7 empty idle", {31'b0, irq_out}, 32'd0);

        // R5: masked-only read does not push
        set_lines(32'h0010_0000);
        rd_chk("R5 push", 12'h030, 32'h10F0);
        rd_chk("R5 masked default", 12'h030, DEF);
        wr(12'h030, 32'h0);
        check("R5 single pop empties", {31'b0, irq_out}, 32'd1);

        // R4: enabling slot5 now claims src9
        set_lines(32'h0000_0200);
        wr(12'h214, 32'h29);
        rd_chk("R4 enabled slot5", 12'h030, 32'h1050);
        wr(12'h030, 32'h0);

        // R10: ack lasts one cycle
        @(negedge clk);
        check("R10 ack low", {31'b0, bus_ack}, 32'd0);

        // R9: reset mid-service
        set_lines(32'h0010_0000);
        rd_chk("R9 pre", 12'h030, 32'h10F0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R9 stack cleared nv", {31'b0, irq_out}, 32'd1);
        rd_chk("R9 slot cleared", 12'h23C, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule